// File: doc/BRIEF.md
# Snapshot Seconds Counter with Byte Command Port

The block keeps a free-running binary count of seconds and a one-byte control register. Both are reached through a byte-level command port that sits behind a bit-serial link: the link layer hands over decoded command bytes and received data bytes, and it pulses a request whenever it needs the next byte to transmit. A separate pulse marks a reset on the bus. Crystal division and bit-level addressing are done elsewhere.

The block has a transfer buffer that is separate from the live count. A read command freezes the live count into the buffer, so the bytes returned never tear while the clock keeps running. A write command first applies the control byte at once, then collects time bytes into the buffer. The next bus reset copies them into the live count in a single cycle. When the oscillator-enable bit is clear, the count stops and keeps whatever was last loaded.

Top module: `rtc_cmd_port`

## Requirements
- R1: After reset the seconds count is 0, and the control byte reads back as 00h.
- R2: While the oscillator bit is set, each `tick_1hz` pulse adds one to the seconds count on the next clock edge. The count wraps from FFFFFFFFh to 0.
- R3: While the oscillator bit is clear, ticks leave the seconds count unchanged.
- R4: The control byte reads back as {user[3:0], osc, osc, 2'b00}. Bits 1:0 are always 0, bits 3 and 2 both show the oscillator state, and bits 7:4 return the user flags last written.
- R5: When a written control byte has different values in bits 3 and 2, bit 3 sets the oscillator state.
- R6: Command 66h copies the live count into the buffer. Each `tx_req` then returns, in order, the control byte and then buffer bytes 7:0, 15:8, 23:16 and 31:24. Ticks that arrive after the command do not change the bytes returned.
- R7: Requests made after the fifth byte start the same five-byte sequence again, from the same snapshot.
- R8: After command 99h, the first received byte is written to the control register and takes effect on the next clock edge, before any bus reset.
- R9: After the control byte, the next four received bytes go into the buffer, least significant first. The live count is unchanged until `bus_reset`, which loads the buffer into it.
- R10: A bus reset after a write loads the count only if at least one time byte was received. Buffer bytes that were not received keep their earlier contents, either a snapshot or earlier data.
- R11: A tick in the same cycle as the commit is dropped, and the count takes the written value.
- R12: During a write, received bytes after the fifth are ignored. They change neither the control register nor the buffer.
- R13: A bus reset that does not follow a write leaves the count unchanged. `tx_req` outside a read produces no `tx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse each second |
| cmd_valid | input | 1 | Function command byte present |
| cmd_byte | input | 8 | Function command code |
| rx_valid | input | 1 | Received data byte present |
| rx_byte | input | 8 | Received data byte |
| tx_req | input | 1 | Link requests the next byte to send |
| bus_reset | input | 1 | Bus reset seen on the link |
| tx_valid | output | 1 | `tx_byte` holds a new byte (one cycle after `tx_req`) |
| tx_byte | output | 8 | Byte to transmit |
| seconds | output | 32 | Live seconds count |

## Verification
Properties check on every cycle that:
- the count holds while stopped and steps by exactly one on a running tick;
- a commit loads the buffer value regardless of a tick;
- the snapshot buffer stays frozen throughout a read;
- the byte index never leaves its range;
- a control write sets the oscillator from bit 3.

The ordering of the returned bytes, the wrap at the fifth byte, the retention of partly written buffers and the discarding of surplus bytes depend on whole command sequences. Only the bench scenarios show those. A sweep of all 256 control values covers the read-back format.

// File: rtl/rtc_cmd_pkg.sv
package rtc_cmd_pkg;
   typedef enum logic [1:0] {
      XF_IDLE  = 2'd0,
      XF_READ  = 2'd1,
      XF_WRITE = 2'd2
   } xfer_mode_e;
endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg #(
   parameter int BYTE_W = 8,
   parameter int USER_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   output logic              osc_run,
   output logic [BYTE_W-1:0] rd_data
);
   localparam int OSC_HI = 3;

   logic              osc_q;
   logic [USER_W-1:0] user_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         osc_q  <= 1'b0;
         user_q <= '0;
      end else if (wr_en) begin
         osc_q  <= wr_data[OSC_HI];
         user_q <= wr_data[BYTE_W-1 -: USER_W];
      end
   end

   assign osc_run = osc_q;
   assign rd_data = {user_q, osc_q, osc_q, 2'b00};

   p_osc_from_bit3_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (osc_run == $past(wr_data[OSC_HI])));

   p_user_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data[BYTE_W-1 -: USER_W] == $past(wr_data[BYTE_W-1 -: USER_W])));
endmodule

// File: rtl/rtc_live_counter.sv
module rtc_live_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (tick && run)
         cnt_q <= cnt_q + 1'b1;
   end

   assign count = cnt_q;

   p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> $stable(count));

   p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !load) |=> (count == $past(count) + 1'b1));

   p_commit_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (count == $past(load_val)));
endmodule

// File: rtl/rtc_xfer_seq.sv
module rtc_xfer_seq
   import rtc_cmd_pkg::*;
#(
   parameter int         CNT_W  = 32,
   parameter int         BYTE_W = 8,
   parameter logic [7:0] CMD_RD = 8'h66,
   parameter logic [7:0] CMD_WR = 8'h99
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_byte,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              tx_req,
   input  logic              bus_reset,
   input  logic [CNT_W-1:0]  live_count,
   input  logic [BYTE_W-1:0] ctrl_rd,
   output logic              ctrl_wr,
   output logic [BYTE_W-1:0] ctrl_wdata,
   output logic              commit,
   output logic [CNT_W-1:0]  buf_out,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_byte
);
   localparam int NB     = CNT_W / BYTE_W;
   localparam int IDX_W  = $clog2(NB + 2);
   localparam int SLOTS  = 2 ** IDX_W;

   xfer_mode_e        mode_q;
   logic [IDX_W-1:0]  idx_q;
   logic              seen_q;
   logic [CNT_W-1:0]  buf_q;
   logic              txv_q;
   logic [BYTE_W-1:0] txb_q;
   logic [BYTE_W-1:0] slot_w [SLOTS];

   assign slot_w[0] = ctrl_rd;
   for (genvar g = 1; g < SLOTS; g++) begin : g_slot
      if (g <= NB) begin : g_data
         assign slot_w[g] = buf_q[(g-1)*BYTE_W +: BYTE_W];
      end else begin : g_pad
         assign slot_w[g] = '0;
      end
   end

   logic in_write, byte_ok;
   assign in_write = (mode_q == XF_WRITE) && !bus_reset && !cmd_valid;
   assign byte_ok  = (idx_q <= IDX_W'(NB));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= XF_IDLE;
         idx_q  <= '0;
         seen_q <= 1'b0;
         buf_q  <= '0;
         txv_q  <= 1'b0;
         txb_q  <= '0;
      end else begin
         txv_q <= 1'b0;
         if (bus_reset) begin
            mode_q <= XF_IDLE;
            idx_q  <= '0;
            seen_q <= 1'b0;
         end else if (cmd_valid) begin
            idx_q  <= '0;
            seen_q <= 1'b0;
            if (cmd_byte == CMD_RD) begin
               mode_q <= XF_READ;
               buf_q  <= live_count;
            end else if (cmd_byte == CMD_WR) begin
               mode_q <= XF_WRITE;
            end else begin
               mode_q <= XF_IDLE;
            end
         end else if (mode_q == XF_READ && tx_req) begin
            txv_q <= 1'b1;
            txb_q <= slot_w[idx_q];
            idx_q <= (idx_q == IDX_W'(NB)) ? '0 : idx_q + 1'b1;
         end else if (mode_q == XF_WRITE && rx_valid && byte_ok) begin
            for (int b = 0; b < NB; b++) begin
               if (idx_q == IDX_W'(b + 1)) begin
                  buf_q[b*BYTE_W +: BYTE_W] <= rx_byte;
                  seen_q <= 1'b1;
               end
            end
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign ctrl_wr    = in_write && rx_valid && (idx_q == '0);
   assign ctrl_wdata = rx_byte;
   assign commit     = bus_reset && (mode_q == XF_WRITE) && seen_q;
   assign buf_out    = buf_q;
   assign tx_valid   = txv_q;
   assign tx_byte    = txb_q;

   p_snapshot_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == XF_READ && !cmd_valid) |=> $stable(buf_q));

   p_read_index_wraps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == XF_READ) |-> (idx_q <= IDX_W'(NB)));

   p_write_index_capped_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == XF_WRITE) |-> (idx_q <= IDX_W'(NB + 1)));

   p_tx_only_in_read_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != XF_READ) |=> !tx_valid);
endmodule

// File: rtl/rtc_cmd_port.sv
module rtc_cmd_port #(
   parameter int         CNT_W  = 32,
   parameter int         BYTE_W = 8,
   parameter int         USER_W = 4,
   parameter logic [7:0] CMD_RD = 8'h66,
   parameter logic [7:0] CMD_WR = 8'h99
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_byte,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              tx_req,
   input  logic              bus_reset,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_byte,
   output logic [CNT_W-1:0]  seconds
);
   if (CNT_W % BYTE_W != 0) begin : g_bad_width
      $error("CNT_W must be a whole number of bytes");
   end
   if (BYTE_W != USER_W + 4) begin : g_bad_ctrl
      $error("control byte must hold USER_W flags plus four fixed bits");
   end

   logic              osc_run, ctrl_wr, commit;
   logic [BYTE_W-1:0] ctrl_rd, ctrl_wdata;
   logic [CNT_W-1:0]  buf_val;

   rtc_ctrl_reg #(.BYTE_W(BYTE_W), .USER_W(USER_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wr_data(ctrl_wdata),
      .osc_run(osc_run), .rd_data(ctrl_rd)
   );

   rtc_live_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .run(osc_run),
      .load(commit), .load_val(buf_val), .count(seconds)
   );

   rtc_xfer_seq #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .CMD_RD(CMD_RD), .CMD_WR(CMD_WR)) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req), .bus_reset(bus_reset),
      .live_count(seconds), .ctrl_rd(ctrl_rd), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
      .commit(commit), .buf_out(buf_val), .tx_valid(tx_valid), .tx_byte(tx_byte)
   );
endmodule

// File: tb/rtc_cmd_port_bench.sv
module rtc_cmd_port_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_1hz = 1'b0, cmd_valid = 1'b0, rx_valid = 1'b0;
   logic        tx_req = 1'b0, bus_reset = 1'b0;
   logic [7:0]  cmd_byte = '0, rx_byte = '0;
   logic        tx_valid;
   logic [7:0]  tx_byte;
   logic [31:0] seconds;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   rtc_cmd_port u_rtc_cmd_port (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .cmd_valid(cmd_valid),
      .cmd_byte(cmd_byte), .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
      .bus_reset(bus_reset), .tx_valid(tx_valid), .tx_byte(tx_byte), .seconds(seconds)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick_1hz = 1'b1;
         @(negedge clk) tick_1hz = 1'b0;
      end
   endtask

   task automatic cmd(input logic [7:0] c);
      @(negedge clk) begin cmd_valid = 1'b1; cmd_byte = c; end
      @(negedge clk) cmd_valid = 1'b0;
   endtask

   task automatic rx(input logic [7:0] b);
      @(negedge clk) begin rx_valid = 1'b1; rx_byte = b; end
      @(negedge clk) rx_valid = 1'b0;
   endtask

   task automatic breset();
      @(negedge clk) bus_reset = 1'b1;
      @(negedge clk) bus_reset = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [7:0] exp);
      @(negedge clk) tx_req = 1'b1;
      @(negedge clk) tx_req = 1'b0;
      chk({tag, " tx_valid"}, {31'd0, tx_valid}, 32'd1);
      chk(tag, {24'd0, tx_byte}, {24'd0, exp});
   endtask

   function automatic logic [7:0] ctrl_img(input logic [7:0] v);
      return {v[7:4], v[3], v[3], 2'b00};
   endfunction

   task automatic write_all(input logic [7:0] c, input logic [31:0] t);
      cmd(8'h99);
      rx(c);
      for (int k = 0; k < 4; k++) rx(t[k*8 +: 8]);
      breset();
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 seconds after reset", seconds, 32'd0);
      cmd(8'h66);
      rd("R1 control after reset", 8'h00);
      rd("R1 byte0 after reset", 8'h00);

      // R4 R5: sweep every control value; no time bytes so no commit (R10)
      for (int v = 0; v < 256; v++) begin
         cmd(8'h99);
         rx(8'(v));
         breset();
         cmd(8'h66);
         rd("R4 R5 control readback", ctrl_img(8'(v)));
         breset();
      end
      chk("R10 no commit without time bytes", seconds, 32'd0);

      // last sweep value FFh leaves oscillator running
      ticks(3);
      chk("R2 three ticks", seconds, 32'd3);

      write_all(8'h00, 32'h0);   // R10: full write loads 0? stop osc first
      chk("R9 full write commits zero", seconds, 32'd0);
      cmd(8'h99); rx(8'h08); rx(8'h03); breset();
      chk("R10 one byte commit", seconds, 32'd3);
      cmd(8'h99); rx(8'h04); breset();   // bit2 set, bit3 clear -> stopped (R5)
      ticks(4);
      chk("R3 stopped holds", seconds, 32'd3);

      // R8 R9: staged write, control effective immediately
      cmd(8'h99);
      rx(8'h08);
      rx(8'hFE); rx(8'hFF); rx(8'hFF); rx(8'hFF);
      chk("R9 live unchanged before reset", seconds, 32'd3);
      ticks(1);
      chk("R8 control active before reset", seconds, 32'd4);
      breset();
      chk("R9 commit on bus reset", seconds, 32'hFFFF_FFFE);
      ticks(1);
      chk("R2 to max", seconds, 32'hFFFF_FFFF);
      ticks(1);
      chk("R2 wrap", seconds, 32'd0);

      // R6 R7: frozen snapshot, cyclic repeat
      write_all(8'h08, 32'h4030_2010);
      cmd(8'h66);
      ticks(2);
      for (int pass = 0; pass < 2; pass++) begin
         rd("R6 R7 ctrl", 8'h0C);
         rd("R6 R7 b0", 8'h10);
         rd("R6 R7 b1", 8'h20);
         rd("R6 R7 b2", 8'h30);
         rd("R6 R7 b3", 8'h40);
      end
      chk("R6 live kept running", seconds, 32'h4030_2012);
      breset();
      chk("R13 reset after read keeps count", seconds, 32'h4030_2012);

      // R10: partial write keeps snapshot bytes
      cmd(8'h99); rx(8'h08); rx(8'hAA); breset();
      chk("R10 partial write", seconds, 32'h4030_20AA);

      // R12: surplus byte ignored
      cmd(8'h99); rx(8'h08);
      rx(8'h01); rx(8'h02); rx(8'h03); rx(8'h04); rx(8'hEE);
      breset();
      chk("R12 time after surplus", seconds, 32'h0403_0201);
      cmd(8'h66);
      rd("R12 control after surplus", 8'h0C);
      breset();

      // R11: tick coinciding with commit
      cmd(8'h99); rx(8'h08);
      rx(8'h05); rx(8'h00); rx(8'h00); rx(8'h00);
      @(negedge clk) begin bus_reset = 1'b1; tick_1hz = 1'b1; end
      @(negedge clk) begin bus_reset = 1'b0; tick_1hz = 1'b0; end
      chk("R11 tick dropped on commit", seconds, 32'd5);
      ticks(1);
      chk("R11 next tick counts", seconds, 32'd6);

      // R13: tx_req outside a read
      @(negedge clk) tx_req = 1'b1;
      @(negedge clk) tx_req = 1'b0;
      chk("R13 no tx outside read", {31'd0, tx_valid}, 32'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule